// File: doc/BRIEF.md
# I2C Master Command Sequencer

This block sits between a software-visible command word and a bit-level I2C engine. A one-cycle write strobe presents a seven-bit command (run, start, stop, acknowledge, high-speed, quick-command and burst flags), a read/write direction bit and a burst byte count. The command is decoded against the current master state (Idle, Master Transmit or Master Receive). A legal command becomes an ordered series of primitive requests to the engine: start, repeated start, address phase, byte receive with ACK or NACK, byte transmit, and stop. The block then commits the next master state.

Burst commands move N bytes, with N taken from the count input. A burst receive acknowledges every byte, or acknowledges all bytes but the last, which it NACKs. Received bytes go into a small FIFO. The engine is held off while that FIFO is full. Some flag combinations are flagged as illegal and raise a sticky error. All other unlisted combinations do nothing.

Top module: `i2c_cmd_seq`

## Requirements
- R1: After reset the master state output is Idle, `busy`, `err` and `eng_req` are low and the receive FIFO is empty. State codes: 0 Idle, 1 Master Transmit, 2 Master Receive.
- R2: `cmd_bits` positions: bit0 run, bit1 start, bit2 stop, bit3 ack, bit4 high-speed, bit5 quick-command, bit6 burst. In Idle, start=1 with run=1 (stop=0, burst=0) issues start then address, and the state becomes Master Receive if `dir_rd`=1, otherwise Master Transmit.
- R3: In Master Receive with start=0 and burst=0: run=1 issues one receive, acknowledged if ack=1 and NACKed if ack=0. Adding stop=1 (with ack=0) appends a stop and moves to Idle. Stop=1 with run=0 issues only a stop and moves to Idle, whatever ack is.
- R4: In Master Receive, burst=1 with run=0 issues `burst_len` receives. With ack=1 all are acknowledged. With ack=0 only the last is NACKed. Stop=1 appends a stop and moves to Idle; otherwise the state stays Master Receive.
- R5: In either active state, start=1 with run or burst issues a repeated start and an address phase. If `dir_rd`=1, the receive variants of R3/R4 follow (stop and ack both set gives no operation), and the state is Master Receive or, with stop, Idle. If `dir_rd`=0, one transmit (run) or `burst_len` transmits (burst) follow, the state is Master Transmit or, with stop, Idle, and ack is ignored.
- R6: In Master Receive without start, run=1 or burst=1 together with stop=1 and ack=1 is illegal. It sets `err`, issues no request and keeps the state. The next accepted legal command clears `err`.
- R7: A command with high-speed or quick-command set, with run and burst both set, or not listed above issues no request and changes neither the state nor `err`.
- R8: `busy` rises after a command with at least one primitive is accepted and falls after the done of its final primitive. The state changes only at that point. Command writes while `busy` is high are ignored.
- R9: `eng_op` codes: 0 start, 1 repeated start, 2 address, 3 receive, 4 transmit, 5 stop. `eng_req` and `eng_op` hold steady from request until `eng_done`, and `eng_req` is never high while not busy.
- R10: Every received byte is written to the FIFO in arrival order. A receive is not requested while the FIFO is full, and the burst resumes once the FIFO is read.
- R11: In Master Transmit with start=0: run=1 issues one transmit, burst=1 issues `burst_len` transmits, and stop=1 appends a stop and moves to Idle. Stop alone issues a stop and moves to Idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_wr | input | 1 | One-cycle command write strobe |
| cmd_bits | input | 7 | Command flags (see R2) |
| dir_rd | input | 1 | Direction: 1 read, 0 write |
| burst_len | input | CNT_W | Byte count for burst commands |
| eng_req | output | 1 | Primitive request to the bit engine |
| eng_op | output | 3 | Primitive code (see R9) |
| eng_ack | output | 1 | For receives: 1 send ACK, 0 send NACK |
| eng_done | input | 1 | One-cycle completion from the engine |
| eng_rx_data | input | DATA_W | Byte received by the engine |
| fifo_rd | input | 1 | Pop the receive FIFO |
| fifo_data | output | DATA_W | Head of the receive FIFO |
| fifo_empty | output | 1 | Receive FIFO empty |
| fifo_full | output | 1 | Receive FIFO full |
| busy | output | 1 | Command in progress |
| err | output | 1 | Sticky illegal-command flag |
| mstate | output | 2 | Current master state (see R1) |

## Verification
On every cycle, the assertions check the engine handshake: the request and its code hold until done, and there is no request while idle. They also check that no receive completes into a full FIFO, that the master state holds while a command runs, that busy only falls on a done, and that a rising error leaves the state and busy untouched. Only the bench scenarios can show that each command variant yields the right primitive order, the right ACK/NACK pattern and the right final state. The same holds for the stall-and-resume behaviour at a full FIFO, the discarding of writes while busy, and the error flag being cleared by a later legal command.

// File: rtl/i2cseq_pkg.sv
// Shared types for the I2C master command sequencer.
// Assumes: command flag positions are fixed by the software-visible word.
package i2cseq_pkg;

    localparam int CMD_W   = 7;
    localparam int CB_RUN   = 0;
    localparam int CB_START = 1;
    localparam int CB_STOP  = 2;
    localparam int CB_ACK   = 3;
    localparam int CB_HS    = 4;
    localparam int CB_QCMD  = 5;
    localparam int CB_BURST = 6;

    typedef enum logic [1:0] {
        MS_IDLE = 2'd0,
        MS_TX   = 2'd1,
        MS_RX   = 2'd2
    } mstate_e;

    typedef enum logic [2:0] {
        OP_START  = 3'd0,
        OP_RSTART = 3'd1,
        OP_ADDR   = 3'd2,
        OP_RX     = 3'd3,
        OP_TX     = 3'd4,
        OP_STOP   = 3'd5
    } op_e;

    typedef enum logic [1:0] {
        DATA_NONE = 2'd0,
        DATA_RX   = 2'd1,
        DATA_TX   = 2'd2
    } data_e;

    typedef enum logic [2:0] {
        PH_IDLE, PH_START, PH_RSTART, PH_ADDR, PH_DATA, PH_STOP
    } phase_e;

    // Decoded action plan for one command.
    typedef struct packed {
        logic    legal;
        logic    illegal;
        logic    do_start;
        logic    do_rstart;
        data_e   data;
        logic    single;
        logic    ack_all;
        logic    do_stop;
        mstate_e next;
    } plan_t;

endpackage

// File: rtl/i2cseq_decode.sv
// Command decoder: maps a command word, direction and current state to a plan.
// Purely combinational. Assumes an address phase always follows (re)start.
module i2cseq_decode
    import i2cseq_pkg::*;
(
    input  logic [CMD_W-1:0] cmd,
    input  logic             dir,
    input  mstate_e          cur,
    output plan_t            plan
);

    logic run, start, stop, ack, hs, qc, burst;

    assign run   = cmd[CB_RUN];
    assign start = cmd[CB_START];
    assign stop  = cmd[CB_STOP];
    assign ack   = cmd[CB_ACK];
    assign hs    = cmd[CB_HS];
    assign qc    = cmd[CB_QCMD];
    assign burst = cmd[CB_BURST];

    // Decode the flag combination against the current master state.
    always_comb begin
        plan      = '0;
        plan.next = cur;
        if (!hs && !qc && !(run && burst)) begin
            if (cur == MS_IDLE) begin
                if (start && run && !burst && !stop) begin
                    plan.legal    = 1'b1;
                    plan.do_start = 1'b1;
                    plan.next     = dir ? MS_RX : MS_TX;
                end
            end else if (start) begin
                if ((run || burst) && !(dir && stop && ack)) begin
                    plan.legal     = 1'b1;
                    plan.do_rstart = 1'b1;
                    plan.data      = dir ? DATA_RX : DATA_TX;
                    plan.single    = run;
                    plan.ack_all   = ack;
                    plan.do_stop   = stop;
                    plan.next      = stop ? MS_IDLE : (dir ? MS_RX : MS_TX);
                end
            end else if (run || burst) begin
                if (cur == MS_RX && stop && ack) begin
                    plan.illegal = 1'b1;
                end else begin
                    plan.legal   = 1'b1;
                    plan.data    = (cur == MS_RX) ? DATA_RX : DATA_TX;
                    plan.single  = run;
                    plan.ack_all = ack;
                    plan.do_stop = stop;
                    plan.next    = stop ? MS_IDLE : cur;
                end
            end else if (stop) begin
                plan.legal   = 1'b1;
                plan.do_stop = 1'b1;
                plan.next    = MS_IDLE;
            end
        end
    end

endmodule

// File: rtl/i2cseq_fifo.sv
// Receive FIFO: synchronous write and read, head visible combinationally.
// Assumes the writer never pushes while full (the sequencer stalls instead).
module i2cseq_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         full
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [AW:0]   cnt;
    logic          do_push, do_pop;

    assign empty   = (cnt == '0);
    assign full    = (cnt == (AW+1)'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rp];

    // Store incoming bytes.
    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= wdata;
    end

    // Advance pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
            cnt <= cnt + (AW+1)'(do_push) - (AW+1)'(do_pop);
        end
    end

endmodule

// File: rtl/i2cseq_ctrl.sv
// Primitive sequencer: runs (re)start, address, data bytes and stop in order
// over a request/done handshake, then commits the next master state.
// Assumes eng_done is a one-cycle pulse given only while eng_req is high.
module i2cseq_ctrl
    import i2cseq_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_wr,
    input  plan_t            plan,
    input  logic [CNT_W-1:0] burst_len,
    input  logic             eng_done,
    input  logic             fifo_full,
    output logic             eng_req,
    output op_e              eng_op,
    output logic             eng_ack,
    output logic             rx_push,
    output logic             busy,
    output logic             err,
    output mstate_e          mstate
);

    phase_e           phase, ph_next, ph_first;
    data_e            pl_data;
    logic             pl_ack, pl_stop;
    mstate_e          pl_next;
    logic [CNT_W-1:0] remain, req_cnt;

    // Phase that follows an address phase (or the first one with no start).
    function automatic phase_e after_addr(data_e d, logic [CNT_W-1:0] n, logic stp);
        if (d != DATA_NONE && n != '0) return PH_DATA;
        else if (stp)                  return PH_STOP;
        else                           return PH_IDLE;
    endfunction

    assign req_cnt  = plan.single ? CNT_W'(1) : burst_len;
    assign ph_first = plan.do_start  ? PH_START  :
                      plan.do_rstart ? PH_RSTART :
                      after_addr(plan.data, req_cnt, plan.do_stop);

    // Next phase: start on a legal command, advance on each done.
    always_comb begin
        ph_next = phase;
        if (phase == PH_IDLE) begin
            if (cmd_wr && plan.legal) ph_next = ph_first;
        end else if (eng_done) begin
            case (phase)
                PH_START, PH_RSTART: ph_next = PH_ADDR;
                PH_ADDR:  ph_next = after_addr(pl_data, remain, pl_stop);
                PH_DATA:  ph_next = (remain == CNT_W'(1)) ?
                                    (pl_stop ? PH_STOP : PH_IDLE) : PH_DATA;
                default:  ph_next = PH_IDLE;
            endcase
        end
    end

    // Latch the plan, count bytes, track error and master state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            pl_data <= DATA_NONE;
            pl_ack  <= 1'b0;
            pl_stop <= 1'b0;
            pl_next <= MS_IDLE;
            remain  <= '0;
            err     <= 1'b0;
            mstate  <= MS_IDLE;
        end else begin
            phase <= ph_next;
            if (phase == PH_IDLE && cmd_wr) begin
                if (plan.illegal) begin
                    err <= 1'b1;
                end else if (plan.legal) begin
                    err     <= 1'b0;
                    pl_data <= plan.data;
                    pl_ack  <= plan.ack_all;
                    pl_stop <= plan.do_stop;
                    pl_next <= plan.next;
                    remain  <= req_cnt;
                    if (ph_first == PH_IDLE) mstate <= plan.next;
                end
            end else if (phase != PH_IDLE && eng_done) begin
                if (phase == PH_DATA) remain <= remain - 1'b1;
                if (ph_next == PH_IDLE) mstate <= pl_next;
            end
        end
    end

    // Drive the engine request, code and ACK choice.
    always_comb begin
        busy    = (phase != PH_IDLE);
        eng_req = busy && !(phase == PH_DATA && pl_data == DATA_RX && fifo_full);
        eng_ack = pl_ack || (remain != CNT_W'(1));
        rx_push = eng_done && phase == PH_DATA && pl_data == DATA_RX;
        case (phase)
            PH_START:  eng_op = OP_START;
            PH_RSTART: eng_op = OP_RSTART;
            PH_ADDR:   eng_op = OP_ADDR;
            PH_DATA:   eng_op = (pl_data == DATA_TX) ? OP_TX : OP_RX;
            default:   eng_op = OP_STOP;
        endcase
    end

endmodule

// File: rtl/i2c_cmd_seq.sv
// Top of the I2C master command sequencer: decoder, sequencer and RX FIFO.
// Assumes a bit engine that answers each request with a one-cycle done.
module i2c_cmd_seq
    import i2cseq_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int CNT_W      = 8,
    parameter int FIFO_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [6:0]        cmd_bits,
    input  logic              dir_rd,
    input  logic [CNT_W-1:0]  burst_len,
    output logic              eng_req,
    output logic [2:0]        eng_op,
    output logic              eng_ack,
    input  logic              eng_done,
    input  logic [DATA_W-1:0] eng_rx_data,
    input  logic              fifo_rd,
    output logic [DATA_W-1:0] fifo_data,
    output logic              fifo_empty,
    output logic              fifo_full,
    output logic              busy,
    output logic              err,
    output logic [1:0]        mstate
);

    plan_t   plan;
    mstate_e st;
    op_e     op;
    logic    rx_push;

    assign mstate = st;
    assign eng_op = op;

    i2cseq_decode u_dec (
        .cmd  (cmd_bits),
        .dir  (dir_rd),
        .cur  (st),
        .plan (plan)
    );

    i2cseq_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_wr    (cmd_wr),
        .plan      (plan),
        .burst_len (burst_len),
        .eng_done  (eng_done),
        .fifo_full (fifo_full),
        .eng_req   (eng_req),
        .eng_op    (op),
        .eng_ack   (eng_ack),
        .rx_push   (rx_push),
        .busy      (busy),
        .err       (err),
        .mstate    (st)
    );

    i2cseq_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (rx_push),
        .wdata (eng_rx_data),
        .pop   (fifo_rd),
        .rdata (fifo_data),
        .empty (fifo_empty),
        .full  (fifo_full)
    );

endmodule

// File: rtl/i2cseq_chk.sv
// Checker for i2c_cmd_seq: handshake, stall and state-commit properties.
module i2cseq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       eng_req,
    input logic [2:0] eng_op,
    input logic       eng_done,
    input logic       fifo_full,
    input logic       busy,
    input logic       err,
    input logic [1:0] mstate
);

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && !eng_done) |=> (eng_req && $stable(eng_op))); // R9

    AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !eng_req); // R9

    AST_NO_RX_INTO_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_done && eng_op == 3'd3) |-> !fifo_full); // R10

    AST_STATE_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(mstate)); // R8

    AST_BUSY_ENDS_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(eng_done)); // R8

    AST_ILLEGAL_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> (!busy && $stable(mstate))); // R6

    AST_STATE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        mstate != 2'd3); // R1

endmodule

bind i2c_cmd_seq i2cseq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .eng_req   (eng_req),
    .eng_op    (eng_op),
    .eng_done  (eng_done),
    .fifo_full (fifo_full),
    .busy      (busy),
    .err       (err),
    .mstate    (mstate)
);

// File: tb/sim_i2c_cmd_seq.sv
module sim_i2c_cmd_seq;

    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 2;
    localparam int WDOG       = 100000;

    localparam logic [2:0] O_S = 3'd0, O_RS = 3'd1, O_A = 3'd2,
                           O_RX = 3'd3, O_TX = 3'd4, O_P = 3'd5;

    typedef struct packed {
        logic [6:0]  cmd;
        logic        dir;
        logic [7:0]  n;
        logic [3:0]  nops;
        logic [17:0] ops;
        logic [5:0]  acks;
        logic [1:0]  st;
        logic        er;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VEC [NV] = '{
        '{7'h03, 1'b1, 8'd0, 4'd2, {O_S,O_S,O_S,O_S,O_A,O_S},     6'b000000, 2'd2, 1'b0}, // R2
        '{7'h01, 1'b0, 8'd0, 4'd1, {O_S,O_S,O_S,O_S,O_S,O_RX},    6'b000000, 2'd2, 1'b0}, // R3
        '{7'h09, 1'b0, 8'd0, 4'd1, {O_S,O_S,O_S,O_S,O_S,O_RX},    6'b000001, 2'd2, 1'b0}, // R3
        '{7'h0D, 1'b0, 8'd0, 4'd0, 18'd0,                         6'b000000, 2'd2, 1'b1}, // R6
        '{7'h48, 1'b0, 8'd3, 4'd3, {O_S,O_S,O_S,O_RX,O_RX,O_RX},  6'b000111, 2'd2, 1'b0}, // R4 R6
        '{7'h40, 1'b0, 8'd3, 4'd3, {O_S,O_S,O_S,O_RX,O_RX,O_RX},  6'b000011, 2'd2, 1'b0}, // R4
        '{7'h4C, 1'b0, 8'd3, 4'd0, 18'd0,                         6'b000000, 2'd2, 1'b1}, // R6
        '{7'h11, 1'b0, 8'd0, 4'd0, 18'd0,                         6'b000000, 2'd2, 1'b1}, // R7
        '{7'h05, 1'b0, 8'd0, 4'd2, {O_S,O_S,O_S,O_S,O_P,O_RX},    6'b000000, 2'd0, 1'b0}, // R3
        '{7'h03, 1'b0, 8'd0, 4'd2, {O_S,O_S,O_S,O_S,O_A,O_S},     6'b000000, 2'd1, 1'b0}, // R2
        '{7'h01, 1'b0, 8'd0, 4'd1, {O_S,O_S,O_S,O_S,O_S,O_TX},    6'b000000, 2'd1, 1'b0}, // R11
        '{7'h42, 1'b1, 8'd2, 4'd4, {O_S,O_S,O_RX,O_RX,O_A,O_RS},  6'b000100, 2'd2, 1'b0}, // R5
        '{7'h0B, 1'b1, 8'd0, 4'd3, {O_S,O_S,O_S,O_RX,O_A,O_RS},   6'b000100, 2'd2, 1'b0}, // R5
        '{7'h07, 1'b0, 8'd0, 4'd4, {O_S,O_S,O_P,O_TX,O_A,O_RS},   6'b000000, 2'd0, 1'b0}, // R5
        '{7'h01, 1'b0, 8'd0, 4'd0, 18'd0,                         6'b000000, 2'd0, 1'b0}, // R7
        '{7'h03, 1'b1, 8'd0, 4'd2, {O_S,O_S,O_S,O_S,O_A,O_S},     6'b000000, 2'd2, 1'b0}, // R2
        '{7'h0C, 1'b0, 8'd0, 4'd1, {O_S,O_S,O_S,O_S,O_S,O_P},     6'b000000, 2'd0, 1'b0}, // R3
        '{7'h03, 1'b0, 8'd0, 4'd2, {O_S,O_S,O_S,O_S,O_A,O_S},     6'b000000, 2'd1, 1'b0}, // R2
        '{7'h44, 1'b0, 8'd2, 4'd3, {O_S,O_S,O_S,O_P,O_TX,O_TX},   6'b000000, 2'd0, 1'b0}, // R11
        '{7'h03, 1'b1, 8'd0, 4'd2, {O_S,O_S,O_S,O_S,O_A,O_S},     6'b000000, 2'd2, 1'b0}, // R2
        '{7'h44, 1'b0, 8'd2, 4'd3, {O_S,O_S,O_S,O_P,O_RX,O_RX},   6'b000001, 2'd0, 1'b0}  // R4
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_wr = 1'b0;
    logic [6:0] cmd_bits = '0;
    logic       dir_rd = 1'b0;
    logic [7:0] burst_len = '0;
    logic       eng_req, eng_ack, eng_done;
    logic [2:0] eng_op;
    logic [7:0] eng_rx_data;
    logic       fifo_rd = 1'b0;
    logic [7:0] fifo_data;
    logic       fifo_empty, fifo_full, busy, err;
    logic [1:0] mstate;

    int         n_checks = 0;
    int         n_fails  = 0;
    logic [2:0] log_op  [256];
    logic       log_ack [256];
    int         log_n = 0;
    int         eng_cnt = 0;
    int         rx_val = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_cmd_seq u0 (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_bits(cmd_bits),
        .dir_rd(dir_rd), .burst_len(burst_len), .eng_req(eng_req),
        .eng_op(eng_op), .eng_ack(eng_ack), .eng_done(eng_done),
        .eng_rx_data(eng_rx_data), .fifo_rd(fifo_rd), .fifo_data(fifo_data),
        .fifo_empty(fifo_empty), .fifo_full(fifo_full), .busy(busy),
        .err(err), .mstate(mstate)
    );

    assign eng_rx_data = rx_val[7:0];

    // Bit engine model: answers a request after LAT cycles and logs it.
    always @(posedge clk) begin
        if (!rst_n) begin
            eng_done <= 1'b0;
            eng_cnt  <= 0;
        end else if (eng_done) begin
            eng_done <= 1'b0;
            eng_cnt  <= 0;
        end else if (eng_req) begin
            if (eng_cnt == LAT-1) begin
                eng_done       <= 1'b1;
                log_op[log_n]  <= eng_op;
                log_ack[log_n] <= eng_ack;
                log_n          <= log_n + 1;
                if (eng_op == O_RX) rx_val <= rx_val + 1;
            end else begin
                eng_cnt <= eng_cnt + 1;
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [6:0] c, input logic d, input logic [7:0] n);
        @(negedge clk);
        cmd_bits  = c;
        dir_rd    = d;
        burst_len = n;
        cmd_wr    = 1'b1;
        @(negedge clk);
        cmd_wr    = 1'b0;
    endtask

    // Wait for the command to finish while draining the FIFO.
    task automatic finish_cmd();
        repeat (2) @(negedge clk);
        while (busy || !fifo_empty) begin
            fifo_rd = !fifo_empty;
            @(negedge clk);
        end
        fifo_rd = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (WDOG) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 mstate", mstate, 0);
        check("R1 busy", busy, 0);
        check("R1 err", err, 0);
        check("R1 eng_req", eng_req, 0);
        check("R1 fifo_empty", fifo_empty, 1);

        // Vector walk
        for (int v = 0; v < NV; v++) begin
            int          base, got;
            logic [17:0] aops;
            logic [5:0]  aacks;
            base = log_n;
            issue(VEC[v].cmd, VEC[v].dir, VEC[v].n);
            finish_cmd();
            got   = log_n - base;
            aops  = '0;
            aacks = '0;
            for (int i = 0; i < got && i < 6; i++) begin
                aops[3*i +: 3] = log_op[base+i];
                aacks[i]       = (log_op[base+i] == O_RX) ? log_ack[base+i] : 1'b0;
            end
            $display("vector %0d cmd=%02h", v, VEC[v].cmd);
            check("vector op count", got, int'(VEC[v].nops));
            check("vector op order", int'(aops), int'(VEC[v].ops));
            check("vector ack pattern", int'(aacks), int'(VEC[v].acks));
            check("vector mstate", mstate, int'(VEC[v].st));
            check("vector err", err, int'(VEC[v].er));
        end

        // R8: a write while busy is ignored
        begin
            int base;
            base = log_n;
            issue(7'h03, 1'b1, 8'd0);
            check("R8 busy after accept", busy, 1);
            issue(7'h05, 1'b0, 8'd0);
            finish_cmd();
            check("R8 ops of first command only", log_n - base, 2);
            check("R8 ignored write left state", mstate, 2);
        end

        // R10: burst receive stalls at a full FIFO, resumes, keeps order
        begin
            int base, rx0;
            base = log_n;
            rx0  = rx_val;
            issue(7'h48, 1'b0, 8'd6);
            repeat (40) @(negedge clk);
            check("R10 fifo full", fifo_full, 1);
            check("R10 still busy", busy, 1);
            check("R10 no request while full", eng_req, 0);
            check("R10 receives before stall", log_n - base, 4);
            for (int i = 0; i < 6; i++) begin
                while (fifo_empty) @(negedge clk);
                check("R10 fifo order", fifo_data, (rx0 + 1 + i) & 8'hFF);
                fifo_rd = 1'b1;
                @(negedge clk);
                fifo_rd = 1'b0;
            end
            finish_cmd();
            check("R10 total receives", log_n - base, 6);
            check("R4 burst stays in receive", mstate, 2);
        end

        // R6 then clear: illegal sets err, next legal clears it
        issue(7'h0D, 1'b0, 8'd0);
        finish_cmd();
        check("R6 err set", err, 1);
        check("R6 state kept", mstate, 2);
        issue(7'h09, 1'b0, 8'd0);
        finish_cmd();
        check("R6 err cleared by legal", err, 0);

        // R7 quick-command flag gives no operation
        begin
            int base;
            base = log_n;
            issue(7'h21, 1'b0, 8'd0);
            finish_cmd();
            check("R7 no primitives", log_n - base, 0);
            check("R7 state kept", mstate, 2);
        end

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule